// File: doc/BRIEF.md
# Eight-bit accumulator ALU

This block is the data path of a small accumulator machine. It holds an 8-bit accumulator, an 8-bit auxiliary register that serves as the second factor, divisor, product high byte and remainder, and three status flags: carry, auxiliary (nibble) carry and overflow. Each clock edge with `exec` high applies one operation selected by a 5-bit code. The operation combines the accumulator with the 8-bit `opnd` input, which the decoder fills from whatever source the instruction names. With `exec` low nothing changes.

The operations cover the following:
- add, add with carry and subtract with borrow;
- increment and decrement;
- AND, OR, exclusive OR and complement;
- rotates left and right, with or without the carry flag in the loop;
- exchange of the two nibbles;
- BCD correction after an addition;
- a compare that only sets carry;
- unsigned 8x8 multiply and 8/8 divide on the accumulator and auxiliary register;
- setting and clearing carry, and loads of both registers.

All results are registered. They appear one clock after the edge that applies the operation.

Top module: `acc_alu`

## Requirements
- R1: After reset (`rst_n` low) the accumulator, the auxiliary register and all three flags read 0.
- R2: With `exec` low, or with codes 0 or 23..31, no register or flag changes. Code 1 loads the accumulator from `opnd`. Code 2 loads the auxiliary register from `opnd`. Neither load touches the flags.
- R3: Codes 3 (add) and 4 (add with carry-in) write A+opnd(+carry) to the accumulator. Carry takes the carry out of bit 7. Auxiliary carry takes the carry out of bit 3. Overflow takes the signed two's-complement overflow.
- R4: Code 5 writes A-opnd-carry to the accumulator. Carry takes the borrow out of bit 7, auxiliary carry the borrow out of bit 3, and overflow the signed overflow.
- R5: Codes 6 (increment) and 7 (decrement) change the accumulator modulo 256 and leave all flags unchanged.
- R6: Codes 12 (AND), 13 (OR) and 14 (XOR) combine the accumulator with `opnd`. Code 15 inverts the accumulator. All four leave the flags unchanged.
- R7: Codes 16 (rotate left) and 17 (rotate right) rotate the accumulator by one bit within itself and leave carry unchanged.
- R8: Code 18 rotates left through carry: bit 7 goes to carry and the old carry goes to bit 0. Code 19 rotates right through carry: bit 0 goes to carry and the old carry goes to bit 7.
- R9: Code 20 exchanges bits 7:4 and 3:0 of the accumulator. Flags are unchanged.
- R10: Code 8 forms the 16-bit product of the accumulator and the auxiliary register. The low byte goes to the accumulator and the high byte to the auxiliary register. Carry is cleared. Overflow is set exactly when the product exceeds 255.
- R11: Code 9 divides the accumulator by the auxiliary register. The quotient goes to the accumulator and the remainder to the auxiliary register, and carry and overflow are cleared. A zero divisor instead sets overflow, clears carry and leaves both registers unchanged.
- R12: Code 10 adds 6 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the high nibble exceeds 9, carry is set, or the first step carried out. Carry is set when either step carries out of bit 7 and is never cleared. The other flags are unchanged.
- R13: Code 11 sets carry exactly when the accumulator is below `opnd` (unsigned). It leaves the accumulator and the other flags unchanged.
- R14: Code 21 sets carry and code 22 clears carry. Nothing else changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec | input | 1 | Apply `op` at this edge |
| op | input | 5 | Operation code |
| opnd | input | 8 | Second operand or load value |
| acc | output | 8 | Accumulator |
| breg | output | 8 | Auxiliary register |
| cy | output | 1 | Carry flag |
| ac | output | 1 | Auxiliary carry flag |
| ov | output | 1 | Overflow flag |

## Verification
Decimal correction is the one operation in which two adjustments fall in the same cycle. The low-nibble fix can carry into the high nibble, and that carry alone must trigger the high-nibble fix and set carry. The bench provokes this on purpose: it adds 0x99 and 0x01 and then applies the correction, expecting 0x00 with carry set. It also runs random add/correct pairs. Results are judged against a bench model of the two-step rule written from the requirement. Multiply and divide are the other case where two results are written at once, and both registers are compared after every operation.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [4:0] op,
  input  logic [7:0] opnd,
  output logic [7:0] acc,
  output logic [7:0] breg,
  output logic       cy,
  output logic       ac,
  output logic       ov
);
  logic [7:0]  na, nb;
  logic        ncy, nac, nov;
  logic        cin;
  logic [8:0]  sum, dif;
  logic [4:0]  sum_lo, dif_lo;
  logic [15:0] prod;
  logic [8:0]  da_lo, da_hi;

  assign cin    = (op == 5'd4 || op == 5'd5) ? cy : 1'b0;
  assign sum    = {1'b0, acc} + {1'b0, opnd} + {8'd0, cin};
  assign sum_lo = {1'b0, acc[3:0]} + {1'b0, opnd[3:0]} + {4'd0, cin};
  assign dif    = {1'b0, acc} - {1'b0, opnd} - {8'd0, cin};
  assign dif_lo = {1'b0, acc[3:0]} - {1'b0, opnd[3:0]} - {4'd0, cin};
  assign prod   = 16'(acc) * 16'(breg);
  assign da_lo  = (acc[3:0] > 4'd9 || ac) ? {1'b0, acc} + 9'd6 : {1'b0, acc};
  assign da_hi  = (da_lo[7:4] > 4'd9 || cy || da_lo[8]) ? {1'b0, da_lo[7:0]} + 9'h060
                                                        : {1'b0, da_lo[7:0]};

  always_comb begin
    na = acc; nb = breg; ncy = cy; nac = ac; nov = ov;
    case (op)
      5'd1: na = opnd;
      5'd2: nb = opnd;
      5'd3, 5'd4: begin
        na = sum[7:0]; ncy = sum[8]; nac = sum_lo[4];
        nov = (acc[7] == opnd[7]) && (sum[7] != acc[7]);
      end
      5'd5: begin
        na = dif[7:0]; ncy = dif[8]; nac = dif_lo[4];
        nov = (acc[7] != opnd[7]) && (dif[7] != acc[7]);
      end
      5'd6: na = acc + 8'd1;
      5'd7: na = acc - 8'd1;
      5'd8: begin
        na = prod[7:0]; nb = prod[15:8]; ncy = 1'b0; nov = |prod[15:8];
      end
      5'd9: begin
        ncy = 1'b0;
        nov = (breg == 8'd0);
        if (breg != 8'd0) begin
          na = acc / breg;
          nb = acc % breg;
        end
      end
      5'd10: begin
        na = da_hi[7:0]; ncy = cy | da_lo[8] | da_hi[8];
      end
      5'd11: ncy = (acc < opnd);
      5'd12: na = acc & opnd;
      5'd13: na = acc | opnd;
      5'd14: na = acc ^ opnd;
      5'd15: na = ~acc;
      5'd16: na = {acc[6:0], acc[7]};
      5'd17: na = {acc[0], acc[7:1]};
      5'd18: begin na = {acc[6:0], cy}; ncy = acc[7]; end
      5'd19: begin na = {cy, acc[7:1]}; ncy = acc[0]; end
      5'd20: na = {acc[3:0], acc[7:4]};
      5'd21: ncy = 1'b1;
      5'd22: ncy = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; breg <= '0; cy <= 1'b0; ac <= 1'b0; ov <= 1'b0;
    end else if (exec) begin
      acc <= na; breg <= nb; cy <= ncy; ac <= nac; ov <= nov;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [4:0] op,
  input logic [7:0] opnd,
  input logic [7:0] acc,
  input logic [7:0] breg,
  input logic       cy,
  input logic       ac,
  input logic       ov
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(acc) && $stable(breg) && $stable(cy) && $stable(ac) && $stable(ov)));

  p_mul_clr_cy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 5'd8) |=> !cy);

  p_div_zero_ov_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 5'd9 && breg == 8'd0) |=> (ov && !cy && $stable(acc) && $stable(breg)));

  p_cmp_keeps_acc_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 5'd11) |=> ($stable(acc) && $stable(ac) && $stable(ov)));

  p_rot_keeps_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == 5'd16 || op == 5'd17)) |=> $stable(cy));

  p_da_never_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 5'd10 && cy) |=> cy);

  p_incdec_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op == 5'd6 || op == 5'd7)) |=> ($stable(cy) && $stable(ac) && $stable(ov)));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opnd(opnd),
  .acc(acc), .breg(breg), .cy(cy), .ac(ac), .ov(ov)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opnd = '0;
  logic [7:0] acc, breg;
  logic       cy, ac, ov;

  int tests = 0;
  int fails = 0;
  logic [7:0] ma = 0, mb = 0;
  logic mcy = 0, mac = 0, mov = 0;

  always #4 clk = ~clk;

  acc_alu u_dut (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opnd(opnd),
                 .acc(acc), .breg(breg), .cy(cy), .ac(ac), .ov(ov));

  function automatic string req_of(input logic [4:0] c);
    case (c)
      5'd3, 5'd4: return "R3";
      5'd5: return "R4";
      5'd6, 5'd7: return "R5";
      5'd12, 5'd13, 5'd14, 5'd15: return "R6";
      5'd16, 5'd17: return "R7";
      5'd18, 5'd19: return "R8";
      5'd20: return "R9";
      5'd8: return "R10";
      5'd9: return "R11";
      5'd10: return "R12";
      5'd11: return "R13";
      5'd21, 5'd22: return "R14";
      default: return "R2";
    endcase
  endfunction

  task automatic model(input logic [4:0] c, input logic [7:0] v);
    int s, lo, p, t;
    logic k;
    k = (c == 5'd4 || c == 5'd5) ? mcy : 1'b0;
    case (c)
      5'd1: ma = v;
      5'd2: mb = v;
      5'd3, 5'd4: begin
        s = int'(ma) + int'(v) + int'(k);
        lo = int'(ma[3:0]) + int'(v[3:0]) + int'(k);
        t = $signed(ma) + $signed(v) + int'(k);
        mcy = s > 255; mac = lo > 15; mov = (t > 127) || (t < -128);
        ma = s[7:0];
      end
      5'd5: begin
        s = int'(ma) - int'(v) - int'(k);
        lo = int'(ma[3:0]) - int'(v[3:0]) - int'(k);
        t = $signed(ma) - $signed(v) - int'(k);
        mcy = s < 0; mac = lo < 0; mov = (t > 127) || (t < -128);
        ma = s[7:0];
      end
      5'd6: ma = ma + 1;
      5'd7: ma = ma - 1;
      5'd8: begin
        p = int'(ma) * int'(mb);
        ma = p[7:0]; mb = p[15:8]; mcy = 0; mov = p > 255;
      end
      5'd9: begin
        mcy = 0;
        if (mb == 0) mov = 1;
        else begin
          mov = 0; p = int'(ma); ma = 8'(p / int'(mb)); mb = 8'(p % int'(mb));
        end
      end
      5'd10: begin
        t = int'(ma);
        if (t % 16 > 9 || mac) t = t + 6;
        if (t > 255) mcy = 1;
        t = t % 256;
        if (t / 16 > 9 || mcy) t = t + 96;
        if (t > 255) mcy = 1;
        ma = 8'(t % 256);
      end
      5'd11: mcy = ma < v;
      5'd12: ma = ma & v;
      5'd13: ma = ma | v;
      5'd14: ma = ma ^ v;
      5'd15: ma = ~ma;
      5'd16: ma = {ma[6:0], ma[7]};
      5'd17: ma = {ma[0], ma[7:1]};
      5'd18: begin k = ma[7]; ma = {ma[6:0], mcy}; mcy = k; end
      5'd19: begin k = ma[0]; ma = {mcy, ma[7:1]}; mcy = k; end
      5'd20: ma = {ma[3:0], ma[7:4]};
      5'd21: mcy = 1;
      5'd22: mcy = 0;
      default: ;
    endcase
  endtask

  task automatic check(input string r);
    tests++;
    if (acc !== ma || breg !== mb || cy !== mcy || ac !== mac || ov !== mov) begin
      fails++;
      $display("FAIL %s: got A=%h B=%h cy=%b ac=%b ov=%b exp A=%h B=%h cy=%b ac=%b ov=%b",
               r, acc, breg, cy, ac, ov, ma, mb, mcy, mac, mov);
    end
  endtask

  task automatic apply(input logic [4:0] c, input logic [7:0] v, input logic en);
    @(negedge clk);
    op = c; opnd = v; exec = en;
    @(negedge clk);
    exec = 1'b0;
    if (en) model(c, v);
    check(en ? req_of(c) : "R2");
  endtask

  task automatic lit(input string r, input logic [7:0] ea, input logic ecy, input logic eov);
    tests++;
    if (acc !== ea || cy !== ecy || ov !== eov) begin
      fails++;
      $display("FAIL %s: got A=%h cy=%b ov=%b exp A=%h cy=%b ov=%b", r, acc, cy, ov, ea, ecy, eov);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // R2: idle with exec low
    apply(5'd1, 8'h55, 1'b0);
    // R12: both nibble fixes in one cycle
    apply(5'd1, 8'h99, 1'b1);
    apply(5'd3, 8'h01, 1'b1);
    apply(5'd10, 8'h00, 1'b1);
    lit("R12", 8'h00, 1'b1, 1'b0);
    // R10: largest product
    apply(5'd1, 8'hFF, 1'b1);
    apply(5'd2, 8'hFF, 1'b1);
    apply(5'd8, 8'h00, 1'b1);
    lit("R10", 8'h01, 1'b0, 1'b1);
    // R11: zero divisor
    apply(5'd2, 8'h00, 1'b1);
    apply(5'd9, 8'h00, 1'b1);
    lit("R11", 8'h01, 1'b0, 1'b1);
    // R13: equal operands do not set carry
    apply(5'd11, 8'h01, 1'b1);
    lit("R13", 8'h01, 1'b0, 1'b1);
    // R3: signed overflow 0x7F+1
    apply(5'd1, 8'h7F, 1'b1);
    apply(5'd3, 8'h01, 1'b1);
    lit("R3", 8'h80, 1'b0, 1'b1);
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] c;
      logic [7:0] v;
      c = 5'($urandom_range(0, 31));
      v = 8'($urandom);
      if (i % 7 == 0) begin
        apply(5'd3, v, 1'b1);
        c = 5'd10;
      end
      if (i % 11 == 0) apply(5'd2, ((i % 3) == 0) ? 8'h00 : v, 1'b1);
      apply(c, v, ($urandom_range(0, 9) != 0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule